// File: doc/BRIEF.md
# Multi-line Display Address Scanner

This block walks the character positions of a text panel during refresh and produces the display-RAM address to read for each one. A panel can be set up as one, two or four text lines. Each line owns a separate window of the 7-bit display-RAM address space. For each position the block reports the line index, the column index inside that line, and the address of the character shown there.

The scan steps one position each cycle that `scan_en` is high. Each line keeps its own horizontal shift offset. A left-shift command moves every position of the selected line so that it shows the next higher address. A right-shift command moves it so that it shows the next lower address. The offset wraps inside that line's window and never spills into another line.

The number of character columns in one panel row is the segment count divided by the font width. A line in one-line or two-line mode spans two panel rows. A line in four-line mode spans one row.

Top module: `disp_addr_scan`

## Requirements
- R1: After reset, `ram_addr`, `line_idx` and `col_idx` are all 0. The active configuration is one line with the 5-dot font, and every shift offset is 0.
- R2: `line_mode` encoding: 00 selects one line, 01 selects two lines, and 10 or 11 select four lines. `font6` = 0 selects the 5-dot font and 1 selects the 6-dot font. Row columns are 120/width, so 24 for the 5-dot font and 20 for the 6-dot font. A line shows twice the row columns in one-line and two-line modes, and the row columns in four-line mode.
- R3: Line windows, given as base and span. One-line mode: 00h, 96 addresses. Two-line mode: 00h and 40h, 48 addresses each. Four-line mode: 00h, 20h, 40h and 60h, 24 addresses each.
- R4: At a rising edge with `scan_en` high, `col_idx` increments. After the last visible column of a line it returns to 0 and `line_idx` advances; after the last line `line_idx` returns to 0. With `scan_en` low the position holds. Outputs reflect an edge immediately after it.
- R5: `ram_addr` = base(line) + ((col + offset(line)) mod span).
- R6: A left shift (`shl_req` high, `shr_req` low) raises the selected line's offset by 1 modulo span. A right shift lowers it by 1 modulo span. For example, after one right shift in one-line mode, column 0 shows 5Fh.
- R7: `shift_line` selects which line a shift acts on, and other lines keep their offsets. A `shift_line` value not below the current line count is ignored.
- R8: If `shl_req` and `shr_req` are both high, no offset changes.
- R9: If `line_mode` or `font6` differs from the active configuration at an edge, the new configuration takes effect and line and column return to 0. Scan and shift requests in that cycle are ignored. A change of `line_mode` clears every offset, while a font-only change keeps them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_mode | input | 2 | Line count select |
| font6 | input | 1 | 1 = 6-dot font, 0 = 5-dot font |
| scan_en | input | 1 | Advance scan position |
| shl_req | input | 1 | Shift selected line left |
| shr_req | input | 1 | Shift selected line right |
| shift_line | input | 2 | Line targeted by a shift |
| ram_addr | output | 7 | Display-RAM read address |
| line_idx | output | 2 | Current line |
| col_idx | output | 6 | Current column inside the line |

## Verification
The bench targets the offset wrap at both ends of each window. A design that wrapped across the whole address space instead of per line would show 7Fh, or a neighbour line's address, after a right shift. It drives the column rollover at 48, 24 and 20 columns. An off-by-one there would skip or repeat a column, or would start a line at the wrong base such as 18h instead of 20h. It also issues shifts aimed at lines that do not exist and simultaneous left and right requests; a design that took either would move an offset the bench can see at column 0. Finally it changes mode and font mid-scan, where stale offsets or positions would produce addresses outside the new window.

// File: rtl/disp_addr_scan.sv
module disp_addr_scan #(
  parameter int ADDR_W    = 7,
  parameter int SEG_COUNT = 120,
  parameter int WINDOW    = 96,
  localparam int COLS5    = SEG_COUNT / 5,
  localparam int COLS6    = SEG_COUNT / 6,
  localparam int COL_W    = $clog2(2 * COLS5)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        line_mode,
  input  logic              font6,
  input  logic              scan_en,
  input  logic              shl_req,
  input  logic              shr_req,
  input  logic [1:0]        shift_line,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [1:0]        line_idx,
  output logic [COL_W-1:0]  col_idx
);
  localparam int SUM_W = ADDR_W + 1;

  logic [1:0]        mode_q;
  logic              font_q;
  logic [COL_W-1:0]  col_q;
  logic [1:0]        line_q;
  logic [ADDR_W-1:0] off_q [4];

  logic              four, two, cfg_chg, mode_chg, do_shift, col_last;
  logic [2:0]        n_lines;
  logic [1:0]        last_line;
  logic [ADDR_W-1:0] span, base;
  logic [COL_W:0]    vis;
  logic [SUM_W-1:0]  sum, wrapped;

  assign four      = mode_q[1];
  assign two       = (mode_q == 2'b01);
  assign n_lines   = four ? 3'd4 : (two ? 3'd2 : 3'd1);
  assign last_line = four ? 2'd3 : (two ? 2'd1 : 2'd0);
  assign span      = four ? ADDR_W'(WINDOW / 4) : (two ? ADDR_W'(WINDOW / 2) : ADDR_W'(WINDOW));
  assign vis       = four ? (COL_W+1)'(font_q ? COLS6 : COLS5)
                          : (COL_W+1)'(font_q ? 2 * COLS6 : 2 * COLS5);
  assign base      = four ? (ADDR_W'(line_q) << (ADDR_W - 2))
                          : (two ? (ADDR_W'(line_q[0]) << (ADDR_W - 1)) : '0);

  assign mode_chg  = (line_mode != mode_q);
  assign cfg_chg   = mode_chg || (font6 != font_q);
  assign do_shift  = !cfg_chg && (shl_req ^ shr_req) && ({1'b0, shift_line} < n_lines);
  assign col_last  = ((COL_W+1)'(col_q) == vis - 1'b1);

  assign sum       = SUM_W'(col_q) + SUM_W'(off_q[line_q]);
  assign wrapped   = (sum >= SUM_W'(span)) ? sum - SUM_W'(span) : sum;
  assign ram_addr  = base + wrapped[ADDR_W-1:0];
  assign line_idx  = line_q;
  assign col_idx   = col_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 2'b00;
      font_q <= 1'b0;
      col_q  <= '0;
      line_q <= '0;
    end else if (cfg_chg) begin
      mode_q <= line_mode;
      font_q <= font6;
      col_q  <= '0;
      line_q <= '0;
    end else if (scan_en) begin
      if (col_last) begin
        col_q  <= '0;
        line_q <= (line_q == last_line) ? 2'd0 : line_q + 2'd1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  for (genvar gi = 0; gi < 4; gi++) begin : g_off
    always_ff @(posedge clk) begin
      if (!rst_n || mode_chg)
        off_q[gi] <= '0;
      else if (do_shift && shift_line == 2'(gi)) begin
        if (shl_req)
          off_q[gi] <= (off_q[gi] == span - 1'b1) ? '0 : off_q[gi] + 1'b1;
        else
          off_q[gi] <= (off_q[gi] == '0) ? span - 1'b1 : off_q[gi] - 1'b1;
      end
    end
  end

  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_addr >= base) && ((ram_addr - base) < span)); // R3
  AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (COL_W+1)'(col_q) < vis); // R4
  AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, line_q} < n_lines); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !cfg_chg) |=> ($stable(col_q) && $stable(line_q))); // R4
  AST_LEFT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_chg && shl_req && !shr_req && shift_line == 2'd0 && off_q[0] == span - 1'b1)
    |=> (off_q[0] == '0)); // R6
  AST_RIGHT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_chg && shr_req && !shl_req && shift_line == 2'd0 && off_q[0] == '0)
    |=> (off_q[0] == $past(span) - 1'b1)); // R6
  AST_BOTH_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_chg && shl_req && shr_req) |=> $stable(off_q[0])); // R8
  AST_CFG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (col_q == '0 && line_q == '0)); // R9
endmodule

// File: tb/disp_addr_scan_bench.sv
module disp_addr_scan_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] line_mode = 2'b00;
  logic       font6 = 1'b0;
  logic       scan_en = 1'b0, shl_req = 1'b0, shr_req = 1'b0;
  logic [1:0] shift_line = 2'b00;
  logic [6:0] ram_addr;
  logic [1:0] line_idx;
  logic [5:0] col_idx;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  int m_mode, m_font, m_col, m_line;
  int m_off [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_addr_scan u_disp_addr_scan (
    .clk(clk), .rst_n(rst_n), .line_mode(line_mode), .font6(font6),
    .scan_en(scan_en), .shl_req(shl_req), .shr_req(shr_req),
    .shift_line(shift_line), .ram_addr(ram_addr), .line_idx(line_idx),
    .col_idx(col_idx));

  function automatic int f_lines(int md);
    return (md >= 2) ? 4 : (md == 1 ? 2 : 1);
  endfunction
  function automatic int f_span(int md);
    return 96 / f_lines(md);
  endfunction
  function automatic int f_vis(int md, int fn);
    int c = fn ? 20 : 24;
    return (md >= 2) ? c : 2 * c;
  endfunction
  function automatic int f_base(int md, int ln);
    return (md >= 2) ? ln * 32 : (md == 1 ? ln * 64 : 0);
  endfunction
  function automatic int f_addr();
    return f_base(m_mode, m_line) + (m_col + m_off[m_line]) % f_span(m_mode);
  endfunction

  task automatic model_reset();
    m_mode = 0; m_font = 0; m_col = 0; m_line = 0;
    foreach (m_off[k]) m_off[k] = 0;
  endtask

  task automatic model_step(int md, int fn, bit sc, bit l, bit r, int sl);
    if (md != m_mode || fn != m_font) begin
      if (md != m_mode) foreach (m_off[k]) m_off[k] = 0;
      m_mode = md; m_font = fn; m_col = 0; m_line = 0;
      return;
    end
    if (l != r && sl < f_lines(m_mode)) begin
      if (l) m_off[sl] = (m_off[sl] + 1) % f_span(m_mode);
      else   m_off[sl] = (m_off[sl] + f_span(m_mode) - 1) % f_span(m_mode);
    end
    if (sc) begin
      if (m_col == f_vis(m_mode, m_font) - 1) begin
        m_col = 0;
        m_line = (m_line == f_lines(m_mode) - 1) ? 0 : m_line + 1;
      end else m_col++;
    end
  endtask

  task automatic check(string tag);
    n_checks++;
    if (ram_addr !== 7'(f_addr()) || line_idx !== 2'(m_line) || col_idx !== 6'(m_col)) begin
      n_fail++;
      $display("FAIL %s: addr/line/col actual=%h/%0d/%0d expected=%h/%0d/%0d",
               tag, ram_addr, line_idx, col_idx, f_addr(), m_line, m_col);
    end
  endtask

  task automatic step(int md, int fn, bit sc, bit l, bit r, int sl);
    @(negedge clk);
    line_mode = 2'(md); font6 = fn[0]; scan_en = sc;
    shl_req = l; shr_req = r; shift_line = 2'(sl);
    @(posedge clk);
    model_step(md, fn, sc, l, r, sl);
    #1;
  endtask

  task automatic scan_n(int n, string tag);
    for (int i = 0; i < n; i++) step(m_mode, m_font, 1, 0, 0, 0);
    check(tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_0A7A));
    model_reset();
    repeat (3) @(posedge clk);
    #1; check("R1 reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1; check("R1 after release");

    step(0, 0, 0, 0, 1, 0); check("R6 right wrap shows 5Fh");
    if (ram_addr !== 7'h5F) begin n_fail++; $display("FAIL R6: actual=%h expected=5f", ram_addr); end
    n_checks++;
    step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 1, 0, 0); check("R6 left shift");
    step(0, 0, 0, 1, 1, 0); check("R8 both shifts");
    step(0, 0, 0, 1, 0, 1); check("R7 shift on absent line");
    scan_n(47, "R4 last column one-line");
    scan_n(1, "R4 column wrap one-line");

    step(1, 0, 1, 1, 0, 0); check("R9 mode change clears");
    scan_n(48, "R3 two-line second base 40h");
    step(1, 0, 0, 1, 0, 1); check("R7 shift line 1");
    step(1, 0, 0, 0, 1, 2); check("R7 shift_line beyond count");
    scan_n(48, "R4 line wrap two-line");

    step(2, 0, 0, 0, 0, 0); check("R9 to four-line");
    scan_n(24, "R3 four-line base 20h");
    step(2, 0, 0, 1, 0, 1); check("R7 four-line line 1");
    step(2, 1, 0, 0, 0, 0); check("R9 font change keeps offsets");
    scan_n(20, "R2 6-dot 20 columns");
    scan_n(40, "R2 four-line line 3");
    step(3, 1, 0, 0, 0, 0); check("R2 mode 11 is four-line");
    step(0, 1, 0, 0, 1, 0); check("R9 to one-line 6-dot");
    scan_n(40, "R2 one-line 6-dot 40 columns");

    for (int i = 0; i < 4000; i++) begin
      int md = ($urandom_range(0, 49) == 0) ? int'($urandom_range(0, 3)) : m_mode;
      int fn = ($urandom_range(0, 59) == 0) ? int'($urandom_range(0, 1)) : m_font;
      step(md, fn, $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0,
           $urandom_range(0, 2) == 0, int'($urandom_range(0, 3)));
      check("R5 random");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R4 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule